// File: doc/BRIEF.md
# Serial Command Monitor for Word Storage

This block reads commands from a stream of received bytes and carries each one out against a word-addressed storage port. Each command begins with one operation byte. Four address bytes follow, lowest byte first. A write command then carries four data bytes, also lowest byte first. A read answers with the four bytes of the addressed word, lowest byte first. Every command, read or write, ends with one status byte sent back.

The byte source and byte sink are byte-wide valid/ready handshakes. They connect straight to a serial receiver and transmitter. The storage port has an address, write data, a one-cycle write strobe, and a read-data input that is valid in the same cycle as the address. Two address windows are set by parameters. One is the window of mapped words. The other is a window that may be read but not written. Addresses outside the mapped window are never written, and reads from them return zeros.

Top module: `cmd_monitor`

## Requirements
- R1: After reset the block accepts input bytes (`rx_ready` high), sends nothing (`tx_valid` low) and does not strobe `mem_we`.
- R2: Operation byte 0x00 starts a read and 0x01 starts a write. Any other value causes one status byte 0x01 (protocol error) and no storage write. The next received byte is then taken as a new operation byte.
- R3: The four bytes after the operation byte form the 32-bit address, first byte in bits 7:0 and last byte in bits 31:24.
- R4: A read of a mapped address sends the stored word as four bytes, bits 7:0 first, then status 0x00.
- R5: A write takes four data bytes after the address, lowest byte first. After the last data byte the block raises `mem_we` for exactly one cycle with the full address and word, then sends status 0x00.
- R6: A read of an unmapped address sends four 0x00 bytes and then status 0x02.
- R7: A write to an unmapped address performs no storage write and sends status 0x02.
- R8: A write to an address inside the read-only window performs no storage write and sends status 0x03. A read there succeeds with status 0x00.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values. Each byte is sent exactly once.
- R10: `rx_ready` is low whenever `tx_valid` is high, so no input byte is taken while a reply is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block takes a received byte this cycle |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Sink takes the reply byte this cycle |
| mem_addr | output | 32 | Storage word address |
| mem_wdata | output | 32 | Storage write word |
| mem_we | output | 1 | Storage write strobe, one cycle |
| mem_rdata | input | 32 | Storage read word for `mem_addr`, same cycle |

## Verification
A parser state that is off by one byte shows up on the very next reply. The status byte arrives a byte early or late, the address is shifted by eight bits, or a data byte comes out in the status position. Each of these is visible within one command. A stale or wrong range decision shows as a wrong status code, or as a change in the write-strobe count, as soon as that command's status byte is sent. A missing reset of the parser means the first command after reset is misread. Broken backpressure handling shows as a changed or repeated byte during a stalled transfer.

// File: rtl/cmdmon_pkg.sv
package cmdmon_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_EXEC,
        ST_REPLY,
        ST_STATUS
    } mon_state_e;

    localparam logic [7:0] OPC_READ     = 8'h00;
    localparam logic [7:0] OPC_WRITE    = 8'h01;

    localparam logic [7:0] STS_OK       = 8'h00;
    localparam logic [7:0] STS_PROTO    = 8'h01;
    localparam logic [7:0] STS_UNMAPPED = 8'h02;
    localparam logic [7:0] STS_READONLY = 8'h03;

endpackage

// File: rtl/cmdmon_byte_asm.sv
module cmdmon_byte_asm #(
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  push_i,
    input  logic [7:0]            byte_i,
    output logic [8*NBYTES-1:0]   word_o,
    output logic                  last_o
);

    localparam int W  = 8 * NBYTES;
    localparam int CW = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
    } asm_t;

    asm_t asm_d, asm_q;

    always_comb begin
        asm_d = asm_q;
        if (clr_i) begin
            asm_d.cnt = '0;
        end else if (push_i) begin
            asm_d.word = (asm_q.word >> 8) | (W'(byte_i) << (W - 8));
            asm_d.cnt  = asm_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign word_o = asm_q.word;
    assign last_o = (asm_q.cnt == CW'(NBYTES - 1));

    // R3: a field never collects more bytes than its width
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        asm_q.cnt <= CW'(NBYTES));

    // R3: a push on the last slot is followed by the field being marked full
    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clr_i && last_o) |=> (asm_q.cnt == CW'(NBYTES)));

endmodule

// File: rtl/cmdmon_range_dec.sv
module cmdmon_range_dec #(
    parameter int          ADDR_W   = 32,
    parameter int unsigned MAP_BASE = 32'h0000_1000,
    parameter int unsigned MAP_LAST = 32'h0000_13FF,
    parameter int unsigned RO_BASE  = 32'h0000_1380,
    parameter int unsigned RO_LAST  = 32'h0000_13FF
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              mapped_o,
    output logic              ro_o
);

    localparam logic [ADDR_W-1:0] MAP_LO = ADDR_W'(MAP_BASE);
    localparam logic [ADDR_W-1:0] MAP_HI = ADDR_W'(MAP_LAST);
    localparam logic [ADDR_W-1:0] RO_LO  = ADDR_W'(RO_BASE);
    localparam logic [ADDR_W-1:0] RO_HI  = ADDR_W'(RO_LAST);

    assign mapped_o = (addr_i >= MAP_LO) && (addr_i <= MAP_HI);
    assign ro_o     = (addr_i >= RO_LO)  && (addr_i <= RO_HI);

endmodule

// File: rtl/cmdmon_tx_sel.sv
module cmdmon_tx_sel #(
    parameter int NBYTES = 4,
    parameter int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic [8*NBYTES-1:0] word_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic [7:0]          byte_o
);

    logic [7:0] lane [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = word_i[8*g +: 8];
    end

    assign byte_o = lane[idx_i];

endmodule

// File: rtl/cmd_monitor.sv
module cmd_monitor
    import cmdmon_pkg::*;
#(
    parameter int          ADDR_BYTES = 4,
    parameter int          DATA_BYTES = 4,
    parameter int unsigned MAP_BASE   = 32'h0000_1000,
    parameter int unsigned MAP_LAST   = 32'h0000_13FF,
    parameter int unsigned RO_BASE    = 32'h0000_1380,
    parameter int unsigned RO_LAST    = 32'h0000_13FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_we,
    input  logic [31:0] mem_rdata
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int DATA_W = 8 * DATA_BYTES;
    localparam int IDX_W  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

    typedef struct packed {
        mon_state_e        st;
        logic              is_wr;
        logic [7:0]        sts;
        logic [DATA_W-1:0] rword;
        logic [IDX_W-1:0]  tidx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              rx_fire, tx_fire;
    logic              addr_push, data_push, field_clr;
    logic              addr_last, data_last;
    logic [ADDR_W-1:0] addr_word;
    logic [DATA_W-1:0] data_word;
    logic              hit_mapped, hit_ro;
    logic [7:0]        reply_byte;

    assign rx_ready  = (ctl_q.st == ST_OPCODE) || (ctl_q.st == ST_ADDR) || (ctl_q.st == ST_DATA);
    assign tx_valid  = (ctl_q.st == ST_REPLY) || (ctl_q.st == ST_STATUS);
    assign rx_fire   = rx_valid && rx_ready;
    assign tx_fire   = tx_valid && tx_ready;
    assign field_clr = (ctl_q.st == ST_OPCODE) && rx_fire;
    assign addr_push = (ctl_q.st == ST_ADDR) && rx_fire;
    assign data_push = (ctl_q.st == ST_DATA) && rx_fire;

    cmdmon_byte_asm #(.NBYTES(ADDR_BYTES)) u_addr_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (field_clr),
        .push_i (addr_push),
        .byte_i (rx_data),
        .word_o (addr_word),
        .last_o (addr_last)
    );

    cmdmon_byte_asm #(.NBYTES(DATA_BYTES)) u_data_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (field_clr),
        .push_i (data_push),
        .byte_i (rx_data),
        .word_o (data_word),
        .last_o (data_last)
    );

    cmdmon_range_dec #(
        .ADDR_W   (ADDR_W),
        .MAP_BASE (MAP_BASE),
        .MAP_LAST (MAP_LAST),
        .RO_BASE  (RO_BASE),
        .RO_LAST  (RO_LAST)
    ) u_range (
        .addr_i   (addr_word),
        .mapped_o (hit_mapped),
        .ro_o     (hit_ro)
    );

    cmdmon_tx_sel #(.NBYTES(DATA_BYTES), .IDX_W(IDX_W)) u_tx_sel (
        .word_i (ctl_q.rword),
        .idx_i  (ctl_q.tidx),
        .byte_o (reply_byte)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_OPCODE: begin
                if (rx_fire) begin
                    if (rx_data == OPC_READ) begin
                        ctl_d.is_wr = 1'b0;
                        ctl_d.st    = ST_ADDR;
                    end else if (rx_data == OPC_WRITE) begin
                        ctl_d.is_wr = 1'b1;
                        ctl_d.st    = ST_ADDR;
                    end else begin
                        ctl_d.sts   = STS_PROTO;
                        ctl_d.st    = ST_STATUS;
                    end
                end
            end
            ST_ADDR: begin
                if (rx_fire && addr_last) begin
                    ctl_d.st = ctl_q.is_wr ? ST_DATA : ST_EXEC;
                end
            end
            ST_DATA: begin
                if (rx_fire && data_last) begin
                    ctl_d.st = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (!hit_mapped) begin
                    ctl_d.sts = STS_UNMAPPED;
                end else if (ctl_q.is_wr && hit_ro) begin
                    ctl_d.sts = STS_READONLY;
                end else begin
                    ctl_d.sts = STS_OK;
                end
                ctl_d.rword = (hit_mapped && !ctl_q.is_wr) ? DATA_W'(mem_rdata) : '0;
                ctl_d.tidx  = '0;
                ctl_d.st    = ctl_q.is_wr ? ST_STATUS : ST_REPLY;
            end
            ST_REPLY: begin
                if (tx_fire) begin
                    if (ctl_q.tidx == IDX_W'(DATA_BYTES - 1)) begin
                        ctl_d.st = ST_STATUS;
                    end else begin
                        ctl_d.tidx = ctl_q.tidx + IDX_W'(1);
                    end
                end
            end
            ST_STATUS: begin
                if (tx_fire) begin
                    ctl_d.st = ST_OPCODE;
                end
            end
            default: ctl_d.st = ST_OPCODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_OPCODE, is_wr: 1'b0, sts: STS_OK, rword: '0, tidx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_data   = (ctl_q.st == ST_STATUS) ? ctl_q.sts : reply_byte;
    assign mem_addr  = 32'(addr_word);
    assign mem_wdata = 32'(data_word);
    assign mem_we    = (ctl_q.st == ST_EXEC) && ctl_q.is_wr && hit_mapped && !hit_ro;

    // R9: a stalled reply byte is held unchanged
    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10: never accept input while a reply byte is offered
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_valid));

    // R5: the storage strobe lasts one cycle and is followed by the status byte
    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we && tx_valid && tx_data == STS_OK));

    // R7: no write leaves the mapped window
    assert_we_mapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= MAP_BASE && mem_addr <= MAP_LAST));

    // R8: no write lands in the read-only window
    assert_we_not_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(mem_addr >= RO_BASE && mem_addr <= RO_LAST));

    // R2: a status byte is accepted only before the next operation byte
    assert_status_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_STATUS && tx_ready) |=> rx_ready);

endmodule

// File: tb/tb_cmd_monitor.sv
module tb_cmd_monitor;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MAP_BASE = 32'h0000_1000;
    localparam logic [31:0] MAP_LAST = 32'h0000_13FF;
    localparam logic [31:0] RO_BASE  = 32'h0000_1380;
    localparam logic [31:0] RO_LAST  = 32'h0000_13FF;
    localparam int WORDS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic [31:0] mem_rdata;

    logic [31:0] mem    [WORDS];
    logic [31:0] shadow [WORDS];
    int          we_cnt = 0;
    logic [31:0] last_we_addr = '0;
    logic [31:0] last_we_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit hold_bad = 0;
    bit dupl_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_monitor dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    function automatic bit in_map(input logic [31:0] a);
        return (a >= MAP_BASE) && (a <= MAP_LAST);
    endfunction

    function automatic bit in_ro(input logic [31:0] a);
        return (a >= RO_BASE) && (a <= RO_LAST);
    endfunction

    function automatic int widx(input logic [31:0] a);
        return int'(a - MAP_BASE);
    endfunction

    function automatic logic [7:0] exp_status(input logic [31:0] a, input bit wr);
        if (!in_map(a)) return 8'h02;
        if (wr && in_ro(a)) return 8'h03;
        return 8'h00;
    endfunction

    always_comb begin
        if (in_map(mem_addr)) mem_rdata = mem[widx(mem_addr)];
        else                  mem_rdata = 32'hDEAD_BEEF;
    end

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            if (in_map(mem_addr)) mem[widx(mem_addr)] <= mem_wdata;
            we_cnt       <= we_cnt + 1;
            last_we_addr <= mem_addr;
            last_we_data <= mem_wdata;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic [7:0] held = 8'h00;
        bit         have = 0;
        forever begin
            @(negedge clk);
            if (tx_valid && rx_ready) dupl_bad = 1;
            if (have && (!tx_valid || tx_data !== held)) hold_bad = 1;
            tx_ready = ($urandom % 3) != 0;
            if (tx_valid && tx_ready) begin
                b = tx_data;
                @(posedge clk);
                #1;
                tx_ready = 1'b0;
                break;
            end else if (tx_valid) begin
                held = tx_data;
                have = 1;
            end else begin
                have = 0;
            end
        end
    endtask

    task automatic send_addr(input logic [31:0] a);
        for (int i = 0; i < 4; i++) send_byte(a[8*i +: 8]);
    endtask

    task automatic do_read(input logic [31:0] a, input string req);
        logic [31:0] got;
        logic [7:0]  b;
        logic [31:0] exp_w;
        exp_w = in_map(a) ? shadow[widx(a)] : 32'h0;
        send_byte(8'h00);
        send_addr(a);
        for (int i = 0; i < 4; i++) begin
            recv_byte(b);
            got[8*i +: 8] = b;
        end
        chk(req, "read word", got, exp_w);
        recv_byte(b);
        chk(req, "read status", {24'h0, b}, {24'h0, exp_status(a, 1'b0)});
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string req);
        int         wc0;
        logic [7:0] b;
        logic [7:0] es;
        es  = exp_status(a, 1'b1);
        wc0 = we_cnt;
        send_byte(8'h01);
        send_addr(a);
        for (int i = 0; i < 4; i++) send_byte(d[8*i +: 8]);
        recv_byte(b);
        chk(req, "write status", {24'h0, b}, {24'h0, es});
        chk(req, "write strobe count", 32'(we_cnt - wc0), (es == 8'h00) ? 32'd1 : 32'd0);
        if (es == 8'h00) begin
            chk(req, "write address", last_we_addr, a);
            chk(req, "write data", last_we_data, d);
            shadow[widx(a)] = d;
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=%0d expected=0", 1);
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] a, d;
        int          wc0;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);

        for (int i = 0; i < WORDS; i++) begin
            mem[i]    = (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
            shadow[i] = (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
        end

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rx_ready after reset", {31'h0, rx_ready}, 32'd1);
        chk("R1", "tx_valid after reset", {31'h0, tx_valid}, 32'd0);
        chk("R1", "mem_we after reset", {31'h0, mem_we}, 32'd0);

        // R3 R5: distinct address bytes, writable word
        do_write(32'h0000_1234, 32'hA1B2_C3D4, "R5");
        // R4: read back and an untouched word
        do_read(32'h0000_1234, "R4");
        do_read(32'h0000_1001, "R4");
        // R3: only the top byte differs from a mapped address
        do_read(32'h0100_1000, "R3");
        // R6: unmapped read below the window, storage returns junk there
        do_read(32'h0000_0FFF, "R6");
        // R7: unmapped writes on both sides of the window
        do_write(32'h0000_1400, 32'h1111_2222, "R7");
        do_write(32'h0000_0FFF, 32'h3333_4444, "R7");
        // R8: read-only window edges
        do_write(32'h0000_1380, 32'hCAFE_F00D, "R8");
        do_write(32'h0000_13FF, 32'h0BAD_0BAD, "R8");
        do_read(32'h0000_1380, "R8");
        do_write(32'h0000_137F, 32'h7777_8888, "R5");
        do_read(32'h0000_137F, "R4");
        do_write(32'h0000_1000, 32'hFFFF_0001, "R5");
        do_read(32'h0000_1000, "R4");

        // R2: bad operation byte gives one protocol status and nothing more
        wc0 = we_cnt;
        send_byte(8'h07);
        recv_byte(b);
        chk("R2", "bad opcode status", {24'h0, b}, 32'h01);
        @(negedge clk);
        chk("R2", "ready for new opcode", {31'h0, rx_ready}, 32'd1);
        chk("R2", "tx idle after status", {31'h0, tx_valid}, 32'd0);
        chk("R2", "no write on bad opcode", 32'(we_cnt - wc0), 32'd0);
        send_byte(8'hFF);
        recv_byte(b);
        chk("R2", "second bad opcode status", {24'h0, b}, 32'h01);
        do_read(32'h0000_1234, "R2");

        // random mix
        for (int n = 0; n < 60; n++) begin
            int unsigned kind;
            kind = $urandom % 4;
            case (kind)
                0: a = MAP_BASE + ($urandom % 32'h380);
                1: a = RO_BASE + ($urandom % 32'h80);
                2: a = $urandom;
                default: a = MAP_BASE + ($urandom % 32'h400);
            endcase
            d = $urandom;
            if (($urandom % 8) == 0) begin
                logic [7:0] op;
                op = 8'h02 + 8'($urandom % 250);
                send_byte(op);
                recv_byte(b);
                chk("R2", "random bad opcode status", {24'h0, b}, 32'h01);
            end else if ($urandom % 2) begin
                do_write(a, d, in_map(a) ? (in_ro(a) ? "R8" : "R5") : "R7");
            end else begin
                do_read(a, in_map(a) ? "R4" : "R6");
            end
        end

        chk("R9", "reply byte held under backpressure", {31'h0, hold_bad}, 32'd0);
        chk("R10", "input closed while replying", {31'h0, dupl_bad}, 32'd0);

        summary();
        $finish;
    end

endmodule